// File: doc/BRIEF.md
# Bus Hold Request Grant Controller

This block hands the shared external bus to an outside master on request and takes it back afterwards. The outside master signals its wish with an active-low hold request that may change at any time relative to the local clock. The request first passes through a synchronizer chain. Once it is seen, the controller closes the internal request port by raising a stall. It then waits until the access sequencer reports no access in flight and an empty queue. Only then does it release the bus: it drops the output enable that drives every address, data and strobe pad, and pulls the active-low hold acknowledge low.

When the request is withdrawn, the acknowledge goes high first. The pads stay floating for a short turnaround so that the two masters never drive at once. The pads are then enabled again, with the sequencer's strobes still idle, for a set number of cycles before the stall lifts. Requests stalled at the port are held by the requester, not lost, and resume in their original order. An access already running when the request arrives runs to its normal end, because the grant waits on the busy flag.

Top module: `bus_hold_ctrl`

## Requirements
- R1: The hold request passes through SYNC_STAGES (default 2) flip-flops before it is used. With default parameters, no output moves until the third rising edge after the request changes.
- R2: When a synchronized request is seen in the idle state, req_stall rises while bus_oe stays 1 and hold_ack_n stays 1. This drain phase lasts at least one cycle.
- R3: hold_ack_n falls only on an edge where acc_busy and acc_pending are both 0. While either is 1, the bus stays driven and unacknowledged.
- R4: Whenever hold_ack_n is 0, bus_oe is 0, meaning all pads are floating.
- R5: Once the grant is given, changes on acc_busy or acc_pending do not affect any output.
- R6: After the synchronized request goes inactive during a grant, hold_ack_n returns to 1. bus_oe stays 0 for TURN_CYC (default 1) more cycles.
- R7: After the turnaround, bus_oe returns to 1 while req_stall stays 1 for RECLAIM_CYC (default 2) cycles. This reclaim window completes even if a new request arrives during it.
- R8: If the request is withdrawn during the drain phase, the controller returns to idle without ever asserting hold_ack_n.
- R9: req_stall is 0 only in the idle state. In particular, it is 1 whenever bus_oe is 0.
- R10: An active-low rst_n forces bus_oe=1, hold_ack_n=1 and req_stall=0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous active-low bus hold request from the outside master |
| acc_busy | input | 1 | Sequencer has an external access in progress |
| acc_pending | input | 1 | Sequencer has internal accesses queued |
| bus_oe | output | 1 | 1 drives the address, data and strobe pads; 0 floats them |
| hold_ack_n | output | 1 | Active-low hold acknowledge to the outside master |
| req_stall | output | 1 | Holds off new requests at the internal request port |

## Verification
The bench holds the request low across a long busy access, then across a pending-only cycle. A design that granted early would drop hold_ack_n in the middle of a running access and cut it short. A request pulled away during the drain phase must leave hold_ack_n untouched; a design that went straight to the grant would hand off the bus for nothing. On release, the bench checks the cycle in which the pads float with the acknowledge already high. This catches a design that drives while the outside master is still on the bus. It then checks the reclaim cycles with the pads driven but the stall still high, and with a new request arriving inside that window. A design that shortened the reclaim would let a strobe start in the first cycle after re-enable. Asynchronous reset in the middle of a grant is checked between clock edges.

// File: rtl/bhg_pkg.sv
package bhg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_GRANT   = 3'd2,
    ST_TURN    = 3'd3,
    ST_RECLAIM = 3'd4
  } bhg_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bhg_sync.sv
module bhg_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic stage_d;
    if (gi == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = chain_q[gi-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[gi] <= RESET_VAL;
      end else begin
        chain_q[gi] <= stage_d;
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];

  initial begin
    assert_min_stages_R1 : assert (STAGES >= 2)
      else $error("R1: synchronizer needs at least two stages");
  end

endmodule

// File: rtl/bhg_timer.sv
module bhg_timer #(
  parameter int TURN_CYC    = 1,
  parameter int RECLAIM_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_turn,
  input  logic load_reclaim,
  output logic done
);

  localparam int MAXC = bhg_pkg::max2(TURN_CYC, RECLAIM_CYC);
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] TURN_LD    = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] RECLAIM_LD = CW'(RECLAIM_CYC - 1);
  localparam logic [CW-1:0] CNT_MAX    = CW'(MAXC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_turn) begin
      cnt_en = 1'b1;
      cnt_d  = TURN_LD;
    end else if (load_reclaim) begin
      cnt_en = 1'b1;
      cnt_d  = RECLAIM_LD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  assert_cnt_bound_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX)
    else $error("R7: window counter out of range");

  assert_load_exclusive_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !(load_turn && load_reclaim))
    else $error("R6: turnaround and reclaim loaded together");

  initial begin
    assert_min_cycles_R7 : assert (TURN_CYC >= 1 && RECLAIM_CYC >= 1)
      else $error("R7: window lengths must be at least one cycle");
  end

endmodule

// File: rtl/bhg_fsm.sv
module bhg_fsm
  import bhg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_on,
  input  logic acc_busy,
  input  logic acc_pending,
  input  logic tmr_done,
  output logic load_turn,
  output logic load_reclaim,
  output logic bus_oe,
  output logic hold_ack_n,
  output logic req_stall
);

  bhg_state_e state_q, state_d;
  logic       oe_d, ack_n_d, stall_d;
  logic       oe_q, ack_n_q, stall_q;
  logic       bus_quiet;

  assign bus_quiet = !acc_busy && !acc_pending;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_on) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!req_on)        state_d = ST_IDLE;
        else if (bus_quiet) state_d = ST_GRANT;
      end
      ST_GRANT:   if (!req_on)  state_d = ST_TURN;
      ST_TURN:    if (tmr_done) state_d = ST_RECLAIM;
      ST_RECLAIM: if (tmr_done) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  assign load_turn    = (state_q == ST_GRANT) && (state_d == ST_TURN);
  assign load_reclaim = (state_q == ST_TURN)  && (state_d == ST_RECLAIM);

  always_comb begin
    oe_d    = 1'b1;
    ack_n_d = 1'b1;
    stall_d = 1'b1;
    unique case (state_d)
      ST_IDLE:    stall_d = 1'b0;
      ST_DRAIN:   ;
      ST_GRANT: begin
        oe_d    = 1'b0;
        ack_n_d = 1'b0;
      end
      ST_TURN:    oe_d = 1'b0;
      ST_RECLAIM: ;
      default:    stall_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b1;
      ack_n_q <= 1'b1;
      stall_q <= 1'b0;
    end else begin
      state_q <= state_d;
      oe_q    <= oe_d;
      ack_n_q <= ack_n_d;
      stall_q <= stall_d;
    end
  end

  assign bus_oe     = oe_q;
  assign hold_ack_n = ack_n_q;
  assign req_stall  = stall_q;

  assert_grant_on_quiet_bus_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n_q) |-> $past(!acc_busy && !acc_pending))
    else $error("R3: grant given while an access was busy or queued");

  assert_float_with_ack_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_q |-> !oe_q)
    else $error("R4: pads driven during grant");

  assert_ack_release_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n_q) |-> $past(!req_on))
    else $error("R6: acknowledge released while request still active");

  assert_reenable_stalled_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> stall_q)
    else $error("R7: pads re-enabled without stall held");

  assert_stall_drop_driven_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_q) |-> ($past(oe_q) && oe_q))
    else $error("R7: stall released before pads were driven");

  assert_stall_when_floating_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> stall_q)
    else $error("R9: request port open while pads float");

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int TURN_CYC    = 1,
  parameter int RECLAIM_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic acc_busy,
  input  logic acc_pending,
  output logic bus_oe,
  output logic hold_ack_n,
  output logic req_stall
);

  logic req_sync_n;
  logic req_on;
  logic tmr_done;
  logic load_turn;
  logic load_reclaim;

  bhg_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(hold_req_n),
    .sync_out(req_sync_n)
  );

  assign req_on = !req_sync_n;

  bhg_timer #(
    .TURN_CYC   (TURN_CYC),
    .RECLAIM_CYC(RECLAIM_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_turn   (load_turn),
    .load_reclaim(load_reclaim),
    .done        (tmr_done)
  );

  bhg_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_on      (req_on),
    .acc_busy    (acc_busy),
    .acc_pending (acc_pending),
    .tmr_done    (tmr_done),
    .load_turn   (load_turn),
    .load_reclaim(load_reclaim),
    .bus_oe      (bus_oe),
    .hold_ack_n  (hold_ack_n),
    .req_stall   (req_stall)
  );

endmodule

// File: tb/tb_bus_hold_ctrl.sv
module tb_bus_hold_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  logic hold_req_n, acc_busy, acc_pending;
  logic bus_oe, hold_ack_n, req_stall;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bus_hold_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req_n (hold_req_n),
    .acc_busy   (acc_busy),
    .acc_pending(acc_pending),
    .bus_oe     (bus_oe),
    .hold_ack_n (hold_ack_n),
    .req_stall  (req_stall)
  );

  // Row: {hold_req_n, acc_busy, acc_pending, exp bus_oe, exp hold_ack_n, exp req_stall}
  // Inputs are applied for one cycle; outputs are compared after that edge.
  localparam int NVEC = 30;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b100_110,  // 0  idle
    6'b000_110,  // 1  R1 first stage only
    6'b000_110,  // 2  R1 second stage, still idle
    6'b000_111,  // 3  R2 drain, stall up, pads driven
    6'b000_001,  // 4  R4 grant on quiet bus
    6'b011_001,  // 5  R5 busy/pending ignored in grant
    6'b100_001,  // 6  release entering synchronizer
    6'b100_001,  // 7  still granted
    6'b100_011,  // 8  R6 ack high, pads still floating
    6'b100_111,  // 9  R7 reclaim, pads driven, stalled
    6'b100_111,  // 10 R7 reclaim second cycle
    6'b100_110,  // 11 R9 idle, stall released
    6'b010_110,  // 12 request during a busy access
    6'b010_110,  // 13
    6'b010_111,  // 14 R2 drain
    6'b011_111,  // 15 R3 busy and pending: no grant
    6'b001_111,  // 16 R3 pending only: no grant
    6'b000_001,  // 17 R3 quiet: grant
    6'b100_001,  // 18
    6'b100_001,  // 19
    6'b100_011,  // 20 R6 turnaround
    6'b100_111,  // 21 R7
    6'b100_111,  // 22 R7
    6'b100_110,  // 23 idle
    6'b010_110,  // 24 request while busy
    6'b010_110,  // 25
    6'b110_111,  // 26 R8 drain entered, request already withdrawn
    6'b110_111,  // 27 R8 still draining, no ack
    6'b110_110,  // 28 R8 back to idle without grant
    6'b100_110   // 29 R8 idle, ack never fell
  };
  localparam int VREQ [NVEC] = '{0,1,1,2,4,5,6,6,6,7,7,9,3,3,2,3,3,3,6,6,6,7,7,9,8,8,8,8,8,8};

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {oe,ack_n,stall} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    hold_req_n  = 1'b1;
    acc_busy    = 1'b0;
    acc_pending = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10", {bus_oe, hold_ack_n, req_stall}, 3'b110);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      {hold_req_n, acc_busy, acc_pending} = VEC[i][5:3];
      step();
      check($sformatf("R%0d row %0d", VREQ[i], i), {bus_oe, hold_ack_n, req_stall}, VEC[i][2:0]);
    end

    // R3: long access with request pending, acknowledge must wait
    hold_req_n = 1'b0;
    acc_busy   = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      check("R3 long busy", {bus_oe, hold_ack_n}, {1'b1, 1'b1});
    end
    acc_busy = 1'b0;
    step();
    check("R4 grant after busy", {bus_oe, hold_ack_n, req_stall}, 3'b001);

    // R7: new request arriving during reclaim
    hold_req_n = 1'b1;
    step();
    step();
    step();
    check("R6 turnaround", {bus_oe, hold_ack_n, req_stall}, 3'b011);
    step();
    check("R7 reclaim start", {bus_oe, hold_ack_n, req_stall}, 3'b111);
    hold_req_n = 1'b0;
    step();
    check("R7 reclaim holds", {bus_oe, hold_ack_n, req_stall}, 3'b111);
    step();
    check("R7 reclaim completes", {bus_oe, hold_ack_n, req_stall}, 3'b110);
    step();
    check("R2 new drain", {bus_oe, hold_ack_n, req_stall}, 3'b111);
    step();
    check("R4 regrant", {bus_oe, hold_ack_n, req_stall}, 3'b001);

    // R10: asynchronous reset in the middle of a grant
    #1 rst_n = 1'b0;
    #1 check("R10 async", {bus_oe, hold_ack_n, req_stall}, 3'b110);
    hold_req_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R10 after release", {bus_oe, hold_ack_n, req_stall}, 3'b110);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule